// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block sits at the home memory of a small shared-memory system with `N_PROC` processors. For every memory block it keeps a presence vector with one bit per processor, and one flag that marks a block held privately and possibly modified by a single cache. Caches send it three kinds of miss traffic: read misses, write misses, and upgrade requests from a cache that already holds a shared copy and wants to write. The home controller answers each one. When needed, it sends invalidations or an owner fetch to other caches, counts their responses, rewrites the directory entry, and sends one reply to the requester.

All four message streams use valid/ready handshakes. A message moves on a rising edge where valid and ready are both high. A sender holds valid and every field steady until that edge. The controller handles one transaction at a time. From the edge that accepts a request until the edge that delivers the reply, `req_ready` stays low, so any new request waits at the edge. The snoop and reply streams wait for the cache side to raise its ready. The response stream is accepted only while responses are still owed.

Request types: 0 is a read miss, 1 is a write miss, 2 is an upgrade and 3 is a no-op. Snoop types: 0 is an invalidate and 1 is an owner fetch. Response types: 0 is an invalidate acknowledge and 1 is fetched data. Reply types: 0 is shared data, 1 is exclusive data and 2 is an upgrade grant.

Top module: `fmdir_home`

## Requirements
- R1: After reset every presence vector and private flag is clear, and every memory word is zero. The controller is idle with `req_ready` high and no snoop or reply valid.
- R2: Take a read miss where the private flag is clear, or where no processor other than the requester is present. It sends no snoop and replies type 0 with the memory word. The requester's presence bit is then set, and the private flag keeps its value.
- R3: Take a read miss where the private flag is set and another processor is present. It sends one snoop of type 1 to that owner. The data in the owner's type 1 response goes to the requester in a type 0 reply and is also written to memory. Afterwards the private flag is clear, and both the owner and the requester are present.
- R4: A write miss sends one type 0 snoop to each present processor other than the requester, in ascending ID order. It then replies type 1 with the memory word. Afterwards only the requester is present and the private flag is set.
- R5: An upgrade sends the same invalidations as R4 and replies type 2 with a zero data field. It leaves the same directory state as R4.
- R6: If the private flag was set when invalidations were sent, the data in the owner's acknowledgement is written to memory. The exclusive reply carries that data. When the flag was clear, the data in acknowledgements is ignored.
- R7: `req_ready` is low from the edge that accepts a non-no-op request until the edge that delivers its reply.
- R8: No reply is offered until the number of responses accepted equals the number of snoops delivered. A response arriving in the same cycle as a snoop handshake is counted.
- R9: A type 3 request is accepted and produces no snoop and no reply. It leaves the directory entry unchanged.
- R10: While a snoop or reply is valid and not yet accepted, it stays valid with every field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 no-op |
| req_src | input | IDW | Requesting processor |
| req_blk | input | BW | Block index |
| snp_valid | output | 1 | Snoop offered to a cache |
| snp_ready | input | 1 | Cache takes the snoop |
| snp_type | output | 2 | 0 invalidate, 1 owner fetch |
| snp_dst | output | IDW | Target processor |
| snp_blk | output | BW | Block index |
| rsp_valid | input | 1 | Cache response offered |
| rsp_ready | output | 1 | Responses still owed |
| rsp_type | input | 2 | 0 acknowledge, 1 fetched data |
| rsp_src | input | IDW | Responding processor |
| rsp_data | input | DW | Data carried by the response |
| rep_valid | output | 1 | Reply offered to requester |
| rep_ready | input | 1 | Requester takes the reply |
| rep_type | output | 2 | 0 shared data, 1 exclusive data, 2 upgrade grant |
| rep_dst | output | IDW | Requester |
| rep_blk | output | BW | Block index |
| rep_data | output | DW | Data word |

## Verification
Two things can happen in the same cycle: a later invalidation is being handed off, and the acknowledgement for an earlier one is being accepted. The response counter must take the decrement without losing a count. To provoke this, the bench's cache agents answer each snoop after a random delay of zero to two cycles, and they drop snoop and reply ready at random. Write misses and upgrades to blocks with up to three sharers then overlap issue and collection. The bench checks that each snoop goes to the next expected processor. It also checks that the reply comes only after every expected snoop has been delivered, and that the reply carries exactly the data predicted for the owner's value or the memory word.

// File: rtl/fmdir_pkg.sv
package fmdir_pkg;
  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_UPGR  = 2'd2;
  localparam logic [1:0] RQ_NOP   = 2'd3;

  localparam logic [1:0] SN_INV   = 2'd0;
  localparam logic [1:0] SN_FETCH = 2'd1;

  localparam logic [1:0] RS_ACK   = 2'd0;
  localparam logic [1:0] RS_DATA  = 2'd1;

  localparam logic [1:0] RP_SHARED = 2'd0;
  localparam logic [1:0] RP_EXCL   = 2'd1;
  localparam logic [1:0] RP_GRANT  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_REPLY} home_st_t;
endpackage

// File: rtl/fmdir_dir_store.sv
module fmdir_dir_store #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DW     = 16,
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_blk,
  output logic [N_PROC-1:0] rd_pres,
  output logic              rd_priv,
  output logic [DW-1:0]     rd_data,
  input  logic              dir_we,
  input  logic [BW-1:0]     dir_blk,
  input  logic [N_PROC-1:0] dir_pres,
  input  logic              dir_priv,
  input  logic              mem_we,
  input  logic [BW-1:0]     mem_blk,
  input  logic [DW-1:0]     mem_wdata
);
  logic [N_PROC-1:0] pres_r [N_BLK];
  logic              priv_r [N_BLK];
  logic [DW-1:0]     mem_r  [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_r[b] <= '0;
        priv_r[b] <= 1'b0;
        mem_r[b]  <= '0;
      end else begin
        if (dir_we && dir_blk == BW'(b)) begin
          pres_r[b] <= dir_pres;
          priv_r[b] <= dir_priv;
        end
        if (mem_we && mem_blk == BW'(b)) mem_r[b] <= mem_wdata;
      end
    end
  end

  assign rd_pres = pres_r[rd_blk];
  assign rd_priv = priv_r[rd_blk];
  assign rd_data = mem_r[rd_blk];
endmodule

// File: rtl/fmdir_snoop_walker.sv
module fmdir_snoop_walker #(
  parameter int N_PROC = 4,
  localparam int IDW = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_PROC-1:0] load_vec,
  input  logic              fire,
  output logic              has_pend,
  output logic [IDW-1:0]    dst
);
  logic [N_PROC-1:0] pend;

  always_comb begin
    dst = '0;
    for (int i = N_PROC - 1; i >= 0; i--) begin
      if (pend[i]) dst = IDW'(i);
    end
  end

  assign has_pend = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= '0;
    else if (load) pend <= load_vec;
    else if (fire) pend <= pend & ~(N_PROC'(1) << dst);
  end
endmodule

// File: rtl/fmdir_ack_counter.sv
module fmdir_ack_counter #(
  parameter int N_PROC = 4,
  localparam int CW = $clog2(N_PROC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (dec && !zero)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/fmdir_home.sv
module fmdir_home
  import fmdir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DW     = 16,
  localparam int IDW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int BW  = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int CW  = $clog2(N_PROC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_type,
  input  logic [IDW-1:0] req_src,
  input  logic [BW-1:0]  req_blk,
  output logic           snp_valid,
  input  logic           snp_ready,
  output logic [1:0]     snp_type,
  output logic [IDW-1:0] snp_dst,
  output logic [BW-1:0]  snp_blk,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [1:0]     rsp_type,
  input  logic [IDW-1:0] rsp_src,
  input  logic [DW-1:0]  rsp_data,
  output logic           rep_valid,
  input  logic           rep_ready,
  output logic [1:0]     rep_type,
  output logic [IDW-1:0] rep_dst,
  output logic [BW-1:0]  rep_blk,
  output logic [DW-1:0]  rep_data
);
  home_st_t        st;
  logic [IDW-1:0]  src_q;
  logic [BW-1:0]   blk_q;
  logic [1:0]      kind_q;
  logic            was_priv_q;
  logic            fetch_q;
  logic [DW-1:0]   rdata_q;

  logic [BW-1:0]     rd_blk;
  logic [N_PROC-1:0] rd_pres;
  logic              rd_priv;
  logic [DW-1:0]     rd_data;
  logic              dir_we;
  logic [N_PROC-1:0] dir_pres;
  logic              dir_priv;
  logic              take_data;

  logic [N_PROC-1:0] src_oh;
  logic [N_PROC-1:0] others;
  logic [CW-1:0]     others_cnt;
  logic              req_fire, snp_fire, rsp_fire, rep_fire;
  logic              go_collect;
  logic              has_pend, cnt_zero;

  assign rd_blk = (st == ST_IDLE) ? req_blk : blk_q;
  assign src_oh = N_PROC'(1) << ((st == ST_IDLE) ? req_src : src_q);
  assign others = rd_pres & ~src_oh;

  always_comb begin
    others_cnt = '0;
    for (int i = 0; i < N_PROC; i++) others_cnt = others_cnt + CW'(others[i]);
  end

  assign req_ready = (st == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign snp_valid = (st == ST_COLLECT) && has_pend;
  assign snp_fire  = snp_valid && snp_ready;
  assign rsp_ready = (st == ST_COLLECT) && !cnt_zero;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign rep_valid = (st == ST_REPLY);
  assign rep_fire  = rep_valid && rep_ready;

  assign go_collect = (req_type != RQ_NOP) && (others != '0) &&
                      ((req_type != RQ_READ) || rd_priv);

  // Responses carrying the owner's data update memory and the reply word.
  assign take_data = rsp_fire && ((rsp_type == RS_DATA) || was_priv_q);

  assign snp_type = fetch_q ? SN_FETCH : SN_INV;
  assign snp_blk  = blk_q;
  assign rep_dst  = src_q;
  assign rep_blk  = blk_q;
  assign rep_type = (kind_q == RQ_READ)  ? RP_SHARED :
                    (kind_q == RQ_WRITE) ? RP_EXCL : RP_GRANT;
  assign rep_data = (kind_q == RQ_UPGR) ? '0 : rdata_q;

  // Directory rewrite happens on the reply handshake.
  assign dir_we = rep_fire;
  always_comb begin
    if (kind_q == RQ_READ) begin
      dir_pres = rd_pres | src_oh;
      dir_priv = fetch_q ? 1'b0 : rd_priv;
    end else begin
      dir_pres = src_oh;
      dir_priv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      src_q      <= '0;
      blk_q      <= '0;
      kind_q     <= RQ_READ;
      was_priv_q <= 1'b0;
      fetch_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_fire && req_type != RQ_NOP) begin
          src_q      <= req_src;
          blk_q      <= req_blk;
          kind_q     <= req_type;
          was_priv_q <= rd_priv;
          fetch_q    <= (req_type == RQ_READ) && go_collect;
          rdata_q    <= rd_data;
          st         <= go_collect ? ST_COLLECT : ST_REPLY;
        end
        ST_COLLECT: begin
          if (take_data) rdata_q <= rsp_data;
          if (!has_pend && cnt_zero) st <= ST_REPLY;
        end
        ST_REPLY: if (rep_fire) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  fmdir_dir_store #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_blk(rd_blk), .rd_pres(rd_pres),
    .rd_priv(rd_priv), .rd_data(rd_data), .dir_we(dir_we), .dir_blk(blk_q),
    .dir_pres(dir_pres), .dir_priv(dir_priv), .mem_we(take_data),
    .mem_blk(blk_q), .mem_wdata(rsp_data)
  );

  fmdir_snoop_walker #(.N_PROC(N_PROC)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(req_fire && go_collect),
    .load_vec(others), .fire(snp_fire), .has_pend(has_pend), .dst(snp_dst)
  );

  fmdir_ack_counter #(.N_PROC(N_PROC)) u_acks (
    .clk(clk), .rst_n(rst_n), .load(req_fire && go_collect),
    .load_val(others_cnt), .dec(rsp_fire), .zero(cnt_zero)
  );

  logic unused_src;
  assign unused_src = ^rsp_src;
endmodule

// File: rtl/fmdir_home_chk.sv
module fmdir_home_chk #(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DW     = 16,
  localparam int IDW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int BW  = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [1:0]     req_type,
  input logic [IDW-1:0] req_src,
  input logic           snp_valid,
  input logic           snp_ready,
  input logic [1:0]     snp_type,
  input logic [IDW-1:0] snp_dst,
  input logic [BW-1:0]  snp_blk,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic           rep_valid,
  input logic           rep_ready,
  input logic [1:0]     rep_type,
  input logic [IDW-1:0] rep_dst,
  input logic [DW-1:0]  rep_data
);
  logic [IDW-1:0] src_seen;
  logic [7:0]     owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_seen <= '0;
      owed     <= '0;
    end else begin
      if (req_valid && req_ready) src_seen <= req_src;
      owed <= owed + 8'(snp_valid && snp_ready) - 8'(rsp_valid && rsp_ready);
    end
  end

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !req_ready);
  assert_reply_after_acks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (owed == 8'd0));
  assert_inv_not_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_type == 2'd0) |-> (snp_dst != src_seen));
  assert_reply_to_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (rep_dst == src_seen));
  assert_nop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd3) |=> (!snp_valid && !rep_valid && req_ready));
  assert_snp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_ready) |=> (snp_valid && $stable(snp_dst) && $stable(snp_type) && $stable(snp_blk)));
  assert_rep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_type) && $stable(rep_data) && $stable(rep_dst)));
endmodule

bind fmdir_home fmdir_home_chk #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DW(DW)) u_chk (.*);

// File: tb/fmdir_home_tb.sv
module fmdir_home_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int NB  = 16;
  localparam int DW  = 16;
  localparam int IDW = 2;
  localparam int BW  = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, snp_ready = 0, rsp_valid = 0, rep_ready = 0;
  logic [1:0] req_type = 0, rsp_type = 0;
  logic [IDW-1:0] req_src = 0, rsp_src = 0;
  logic [BW-1:0] req_blk = 0;
  logic [DW-1:0] rsp_data = 0;
  logic req_ready, snp_valid, rsp_ready, rep_valid;
  logic [1:0] snp_type, rep_type;
  logic [IDW-1:0] snp_dst, rep_dst;
  logic [BW-1:0] snp_blk, rep_blk;
  logic [DW-1:0] rep_data;

  fmdir_home #(.N_PROC(NP), .N_BLK(NB), .DW(DW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [NP-1:0] m_pres [NB];
  logic          m_priv [NB];
  logic [DW-1:0] m_mem  [NB];
  logic [DW-1:0] own_val [NB];

  int q_due [8]; logic [1:0] q_typ [8]; logic [IDW-1:0] q_src [8]; logic [DW-1:0] q_dat [8];
  int q_h = 0, q_t = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int popc(input logic [NP-1:0] v);
    int c = 0;
    for (int i = 0; i < NP; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int lowest(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_req(input logic [1:0] t, input int src, input int blk);
    logic [NP-1:0] bitv = NP'(1) << src;
    logic [NP-1:0] oth  = m_pres[blk] & ~bitv;
    bit fetch = (t == 0) && m_priv[blk] && (oth != 0);
    bit coll  = (t != 3) && (oth != 0) && ((t != 0) || m_priv[blk]);
    logic [NP-1:0] rem = coll ? oth : '0;
    int nexp = coll ? popc(oth) : 0;
    int nsnp = 0, k = 0;
    bit done = 0, pop = 0;
    logic [DW-1:0] edata;
    string tg;
    tg = (t == 0) ? (fetch ? "R3" : "R2") : (t == 1 ? ((coll && m_priv[blk]) ? "R6" : "R4") : "R5");
    edata = (t == 2) ? '0 : ((fetch || (coll && m_priv[blk])) ? own_val[blk] : m_mem[blk]);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 idle ready", int'(req_ready), 1);
    req_valid = 1; req_type = t; req_src = IDW'(src); req_blk = BW'(blk);
    @(negedge clk);
    req_valid = 0;
    if (t == 3) begin
      for (int i = 0; i < 3; i++) begin
        chk(!snp_valid && !rep_valid && req_ready, "R9 no-op silent", int'({snp_valid, rep_valid}), 0);
        @(negedge clk);
      end
      return;
    end
    chk(req_ready == 1'b0, "R7 busy after accept", int'(req_ready), 0);
    while (!done && k < 300) begin
      if (k > 0) @(negedge clk);
      k++;
      if (pop) begin rsp_valid = 0; q_h = (q_h + 1) % 8; pop = 0; end
      if (rep_valid) begin
        chk(!req_ready, "R7 busy while replying", int'(req_ready), 0);
        rep_ready = ($urandom % 4) != 0;
        if (rep_ready) begin
          chk(nsnp == nexp, {tg, " snoop count"}, nsnp, nexp);
          chk(rep_type == t, {tg, " reply type"}, int'(rep_type), int'(t));
          chk(rep_dst == IDW'(src) && rep_blk == BW'(blk), {tg, " reply target"}, int'(rep_dst), src);
          chk(rep_data == edata, {tg, " reply data"}, int'(rep_data), int'(edata));
          done = 1;
        end
      end else rep_ready = 0;
      snp_ready = 0;
      if (snp_valid) begin
        snp_ready = ($urandom % 3) != 0;
        if (snp_ready) begin
          chk(int'(snp_dst) == lowest(rem), "R4 snoop target order", int'(snp_dst), lowest(rem));
          chk(snp_type == (fetch ? 2'd1 : 2'd0), fetch ? "R3 fetch type" : "R4 inv type", int'(snp_type), int'(fetch));
          chk(snp_blk == BW'(blk), "R4 snoop block", int'(snp_blk), blk);
          if (lowest(rem) >= 0) rem[lowest(rem)] = 1'b0;
          nsnp++;
          q_due[q_t] = cyc + int'($urandom % 3);
          q_typ[q_t] = fetch ? 2'd1 : 2'd0;
          q_src[q_t] = snp_dst;
          q_dat[q_t] = (fetch || m_priv[blk]) ? own_val[blk] : DW'($urandom);
          q_t = (q_t + 1) % 8;
        end
      end
      if (!rsp_valid && q_h != q_t && q_due[q_h] <= cyc) begin
        rsp_valid = 1; rsp_type = q_typ[q_h]; rsp_src = q_src[q_h]; rsp_data = q_dat[q_h];
      end
      #1;
      pop = rsp_valid && rsp_ready;
    end
    @(negedge clk);
    rep_ready = 0; snp_ready = 0;
    if (pop) begin rsp_valid = 0; q_h = (q_h + 1) % 8; end
    chk(done, {tg, " reply delivered"}, int'(done), 1);
    chk(q_h == q_t, "R8 all responses taken", q_t - q_h, 0);
    if (t == 0) begin
      m_pres[blk] = m_pres[blk] | bitv;
      if (fetch) begin m_priv[blk] = 0; m_mem[blk] = own_val[blk]; end
    end else begin
      if (coll && m_priv[blk]) m_mem[blk] = own_val[blk];
      m_pres[blk] = bitv; m_priv[blk] = 1; own_val[blk] = DW'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) begin
      m_pres[b] = '0; m_priv[b] = 0; m_mem[b] = '0; own_val[b] = DW'($urandom);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !snp_valid && !rep_valid, "R1 reset idle", int'({req_ready, snp_valid, rep_valid}), 4);
    // Directed: sharing, ownership, fetch, upgrade, owner writeback, no-op
    run_req(0, 0, 0);  // R2 data zero
    run_req(0, 1, 0);  // R2 second sharer
    run_req(1, 2, 0);  // R4 invalidate P0, P1
    run_req(0, 3, 0);  // R3 fetch from P2
    run_req(0, 0, 0);  // R2 memory now holds fetched value
    run_req(2, 3, 0);  // R5 invalidate P0, P2
    run_req(1, 1, 0);  // R6 owner P3 ack carries data
    run_req(3, 2, 0);  // R9 no-op
    run_req(1, 0, 0);  // R9 check: only P1 invalidated
    run_req(1, 2, 5);  // R4 empty block, no snoops
    run_req(0, 2, 5);  // R2 requester is owner, memory path
    for (int i = 0; i < 400; i++)
      run_req(2'($urandom % 4), int'($urandom % NP), int'($urandom % 4));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule